// File: doc/BRIEF.md
# Framebuffer Read Fetcher with Credit-Limited Single-Beat Reads

This block moves a 16-bit-per-pixel framebuffer from memory to a raster display. When the display side pulses `frame_start`, the block takes the host-supplied base address. It then issues single-beat 32-bit reads on an AXI read channel, one word after another in increasing address order, until the whole frame has been requested. Read data goes into a local FIFO. Any number of reads may be in flight at once. The only limit is a credit count equal to the FIFO space that is not yet spoken for. Memory latency is hidden by keeping many reads in flight, not by using bursts.

The pixel side runs on the display-enable strobe. It pops one word for every two enabled cycles and sends out the lower halfword first and the upper halfword second. The FIFO read takes two register stages. The enable and sync inputs are delayed by the same two cycles, so pixels and timing leave the block together.

The host may change `fb_base` at any time. The new value is used only from the next frame start, so swapping between two buffers cannot tear an image. A read response carrying an error code sets a sticky flag. Its data is still stored and shown.

Top module: `fb_fetch_top`

## Requirements
- R1: After reset, `m_arvalid`, `pix_de`, `pix_hs`, `pix_vs` and `rd_err` are 0, `pix_data` is 0, and `m_rready` is 1.
- R2: After a `frame_start` pulse, the k-th accepted read address is the latched base plus 4*k. Every read is one 32-bit word.
- R3: Exactly H_PIXELS*V_LINES/2 reads are accepted per frame. After the last one, `m_arvalid` stays low until the next `frame_start`.
- R4: Reads accepted but not yet answered, plus words held in the FIFO, never exceed FIFO_DEPTH. With no pixels consumed, exactly FIFO_DEPTH reads are issued and then `m_arvalid` drops.
- R5: `fb_base` is sampled only when a frame starts. A change made during a frame has no effect on that frame's addresses and applies to the next frame.
- R6: Pixels come out in address order. Each word gives its bits [15:0] on the first enabled cycle and its bits [31:16] on the second. `pix_data` is 0 whenever `pix_de` is 0. The phase restarts at the low half after each gap in `vid_de`.
- R7: `pix_de`, `pix_hs` and `pix_vs` equal `vid_de`, `vid_hs` and `vid_vs` delayed by exactly 2 clock cycles.
- R8: A read response with `m_rresp[1]` set (codes 2 and 3) sets `rd_err`, which stays 1 until reset. The word is still stored and displayed.
- R9: Once `m_arvalid` is high without `m_arready`, it stays high with `m_araddr` unchanged until the handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and pixel logic |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_base | input | 32 | Host framebuffer base byte address |
| frame_start | input | 1 | One-cycle start-of-frame pulse |
| vid_de | input | 1 | Display enable from the timing generator |
| vid_hs | input | 1 | Horizontal sync from the timing generator |
| vid_vs | input | 1 | Vertical sync from the timing generator |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready (back-pressure from memory) |
| m_araddr | output | 32 | Read byte address, word aligned |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready, always 1 because credit reserves space |
| m_rdata | input | 32 | Read data word, two pixels |
| m_rresp | input | 2 | Read response code |
| pix_de | output | 1 | Delayed display enable |
| pix_hs | output | 1 | Delayed horizontal sync |
| pix_vs | output | 1 | Delayed vertical sync |
| pix_data | output | 16 | Pixel value |
| rd_err | output | 1 | Sticky read error flag |

## Verification
The memory model lowers `m_arready` at random and answers in order after a random delay. This tests two things: that a stalled address holds steady, and that the count of reads in flight never goes beyond the credit. A credit counter that leaked would show up either as too many reads in flight or as the fetch stalling for good. A fetch that is not throttled by consumption is caught by starting a frame with `vid_de` low: the design must stop after exactly FIFO_DEPTH reads. The base is changed in the middle of a frame, which would show up as addresses from the wrong buffer if the design sampled it continuously. The bench also watches for any read issued after the last word of a frame, for swapped halfwords, and for a sync delay off by one cycle.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } vid_ctl_t;
endpackage

// File: rtl/fbf_issue.sv
// Read-address generator with a credit counter sized to the FIFO.
module fbf_issue #(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 153600,
  parameter int DEPTH  = 16,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              pop,
  input  logic              arready,
  output logic              arvalid,
  output logic [ADDR_W-1:0] araddr
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int CR_W  = $clog2(DEPTH + 1);
  localparam int BSH   = $clog2(BYTES);

  logic [CR_W-1:0]   credit;
  logic [IDX_W-1:0]  widx;
  logic [ADDR_W-1:0] base_act;
  logic              fetching, sof_pend, hs, restart;

  assign arvalid = fetching && (credit != '0);
  assign araddr  = base_act + (ADDR_W'(widx) << BSH);
  assign hs      = arvalid && arready;
  // a frame restart waits until no address is held stalled on the bus
  assign restart = (sof || sof_pend) && !(arvalid && !arready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit   <= CR_W'(DEPTH);
      widx     <= '0;
      base_act <= '0;
      fetching <= 1'b0;
      sof_pend <= 1'b0;
    end else begin
      credit   <= credit - CR_W'(hs) + CR_W'(pop);
      sof_pend <= (sof || sof_pend) && !restart;
      if (restart) begin
        base_act <= base_in;
        widx     <= '0;
        fetching <= 1'b1;
      end else if (hs) begin
        if (widx == IDX_W'(WORDS - 1)) fetching <= 1'b0;
        widx <= widx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbf_fifo.sv
// Synchronous FIFO with a registered read port.
module fbf_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic                         rd_en,
  output logic [DW-1:0]                rd_data,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) begin
        rptr    <= rptr + 1'b1;
        rd_data <= mem[rptr];
      end
      count <= count + ($bits(count))'(wr_en) - ($bits(count))'(rd_en);
    end
  end
endmodule

// File: rtl/fbf_unpack.sv
// Pixel-side word splitter and two-stage timing delay.
module fbf_unpack
  import fbf_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  vid_ctl_t      vid_in,
  input  logic          empty,
  input  logic [DW-1:0] rd_data,
  output logic          pop,
  output vid_ctl_t      vid_out,
  output logic [PW-1:0] pix
);
  localparam int PPW  = DW / PW;
  localparam int PH_W = (PPW > 1) ? $clog2(PPW) : 1;

  logic [PH_W-1:0] phase, ph_d1, ph_d2;
  vid_ctl_t        ctl_d1, ctl_d2;
  logic            pop_d1;
  logic [DW-1:0]   word_q;

  assign pop     = vid_in.de && (phase == '0) && !empty;
  assign vid_out = ctl_d2;
  assign pix     = ctl_d2.de ? word_q[32'(ph_d2) * PW +: PW] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      ph_d1  <= '0;
      ph_d2  <= '0;
      ctl_d1 <= '0;
      ctl_d2 <= '0;
      pop_d1 <= 1'b0;
      word_q <= '0;
    end else begin
      if (!vid_in.de || phase == PH_W'(PPW - 1)) phase <= '0;
      else                                       phase <= phase + 1'b1;
      ph_d1  <= phase;
      ph_d2  <= ph_d1;
      ctl_d1 <= vid_in;
      ctl_d2 <= ctl_d1;
      pop_d1 <= pop;
      if (pop_d1) word_q <= rd_data;
    end
  end
endmodule

// File: rtl/fb_fetch_top.sv
module fb_fetch_top
  import fbf_pkg::*;
#(
  parameter int H_PIXELS   = 640,
  parameter int V_LINES    = 480,
  parameter int PIX_W      = 16,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fb_base,
  input  logic              frame_start,
  input  logic              vid_de,
  input  logic              vid_hs,
  input  logic              vid_vs,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [ADDR_W-1:0] m_araddr,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  output logic              pix_de,
  output logic              pix_hs,
  output logic              pix_vs,
  output logic [PIX_W-1:0]  pix_data,
  output logic              rd_err
);
  localparam int WORDS = H_PIXELS * V_LINES / (DATA_W / PIX_W);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic              pop, empty;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  fifo_cnt;
  vid_ctl_t          vin, vout;

  assign m_rready = 1'b1;
  assign vin      = '{de: vid_de, hs: vid_hs, vs: vid_vs};
  assign pix_de   = vout.de;
  assign pix_hs   = vout.hs;
  assign pix_vs   = vout.vs;

  fbf_issue #(.ADDR_W(ADDR_W), .WORDS(WORDS), .DEPTH(FIFO_DEPTH), .BYTES(DATA_W / 8)) u_issue (
    .clk(clk), .rst_n(rst_n), .sof(frame_start), .base_in(fb_base), .pop(pop),
    .arready(m_arready), .arvalid(m_arvalid), .araddr(m_araddr)
  );

  fbf_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(m_rvalid), .wr_data(m_rdata),
    .rd_en(pop), .rd_data(rd_data), .empty(empty), .count(fifo_cnt)
  );

  fbf_unpack #(.DW(DATA_W), .PW(PIX_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .vid_in(vin), .empty(empty), .rd_data(rd_data),
    .pop(pop), .vid_out(vout), .pix(pix_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                   rd_err <= 1'b0;
    else if (m_rvalid && m_rresp[1]) rd_err <= 1'b1;
  end
endmodule

// File: rtl/fbf_checker.sv
module fbf_checker #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic [ADDR_W-1:0] m_araddr,
  input logic              m_rvalid,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic              vid_de,
  input logic              vid_hs,
  input logic              vid_vs,
  input logic              pix_de,
  input logic              pix_hs,
  input logic              pix_vs,
  input logic              rd_err
);
  logic [CNT_W+1:0] infl;
  logic [1:0]       warm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      infl <= '0;
      warm <= '0;
    end else begin
      infl <= infl + ($bits(infl))'(m_arvalid && m_arready) - ($bits(infl))'(m_rvalid);
      if (warm != 2'd2) warm <= warm + 1'b1;
    end
  end

  AST_CREDIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(infl) + 32'(fifo_cnt)) <= DEPTH); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid |-> 32'(fifo_cnt) < DEPTH); // R4
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> rd_err); // R8
  AST_CTL_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (pix_de == $past(vid_de, 2) && pix_hs == $past(vid_hs, 2)
                        && pix_vs == $past(vid_vs, 2))); // R7
endmodule

bind fb_fetch_top fbf_checker #(
  .ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .m_arvalid(m_arvalid), .m_arready(m_arready),
  .m_araddr(m_araddr), .m_rvalid(m_rvalid), .fifo_cnt(fifo_cnt),
  .vid_de(vid_de), .vid_hs(vid_hs), .vid_vs(vid_vs),
  .pix_de(pix_de), .pix_hs(pix_hs), .pix_vs(pix_vs), .rd_err(rd_err)
);

// File: tb/sim_fb_fetch_top.sv
`timescale 1ns/1ps
module sim_fb_fetch_top;
  localparam int H = 16, V = 3, DEPTH = 8;
  localparam int WORDS = H * V / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] fb_base = '0;
  logic frame_start = 1'b0, vid_de = 1'b0, vid_hs = 1'b0, vid_vs = 1'b0;
  logic m_arvalid, m_arready = 1'b0, m_rvalid = 1'b0, m_rready;
  logic [31:0] m_araddr, m_rdata = '0;
  logic [1:0] m_rresp = '0;
  logic pix_de, pix_hs, pix_vs, rd_err;
  logic [15:0] pix_data;

  always #5 clk = ~clk;

  fb_fetch_top #(.H_PIXELS(H), .V_LINES(V), .FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .fb_base(fb_base), .frame_start(frame_start),
    .vid_de(vid_de), .vid_hs(vid_hs), .vid_vs(vid_vs),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp),
    .pix_de(pix_de), .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_data(pix_data), .rd_err(rd_err)
  );

  int n_vec = 0, n_fail = 0, cyc = 0;
  logic [31:0] q_addr [64];
  int q_due [64];
  int head = 0, tail = 0, last_due = 0;
  logic [31:0] ar_log [256];
  int ar_cnt = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] exp_base = '0;
  int pix_idx = 0;
  bit prev_stall = 0;
  logic [31:0] prev_addr = '0;

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory slave: random arready, in-order responses after random delay
  initial forever begin
    @(negedge clk);
    cyc++;
    if (m_rvalid) head++;
    if (prev_stall) chk(m_arvalid && m_araddr == prev_addr, "R9", "stalled address held", m_araddr, prev_addr);
    m_arready = ($urandom % 4) != 0;
    prev_stall = m_arvalid && !m_arready;
    prev_addr  = m_araddr;
    if (m_arvalid && m_arready) begin
      int d;
      d = cyc + 1 + int'($urandom % 6);
      if (d <= last_due) d = last_due + 1;
      last_due = d;
      q_addr[tail % 64] = m_araddr;
      q_due[tail % 64]  = d;
      tail++;
      if (ar_cnt < 256) ar_log[ar_cnt] = m_araddr;
      ar_cnt++;
      chk(tail - head <= DEPTH, "R4", "reads in flight", 32'(tail - head), 32'(DEPTH));
    end
    if (head != tail && q_due[head % 64] <= cyc) begin
      m_rvalid = 1'b1;
      m_rdata  = word_of(q_addr[head % 64]);
      m_rresp  = (q_addr[head % 64] == err_addr) ? 2'd2 : 2'd0;
    end else begin
      m_rvalid = 1'b0;
      m_rresp  = 2'd0;
    end
  end

  // pixel monitor (R6)
  initial forever begin
    @(negedge clk);
    if (rst_n && pix_de) begin
      logic [31:0] w;
      logic [15:0] e;
      w = word_of(exp_base + 32'(4 * (pix_idx / 2)));
      e = (pix_idx % 2 == 1) ? w[31:16] : w[15:0];
      chk(pix_data == e, "R6", "pixel value", 32'(pix_data), 32'(e));
      pix_idx++;
    end else if (rst_n) begin
      if (pix_data != 16'h0) chk(1'b0, "R6", "blank pixel", 32'(pix_data), 32'h0);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sof();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic play_frame();
    for (int l = 0; l < V; l++) begin
      vid_de = 1'b1;
      idle(H);
      vid_de = 1'b0;
      idle(3); vid_hs = 1'b1; idle(2); vid_hs = 1'b0; idle(5);
    end
    idle(10);
  endtask

  task automatic check_addrs(input logic [31:0] base, input int n, input string req);
    for (int k = 0; k < n; k++)
      chk(ar_log[k] == base + 32'(4 * k), req, "read address order", ar_log[k], base + 32'(4 * k));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(m_arvalid == 1'b0, "R1", "arvalid after reset", 32'(m_arvalid), 0);
    chk(pix_de == 1'b0 && pix_hs == 1'b0 && pix_vs == 1'b0, "R1", "video out after reset",
        {29'b0, pix_de, pix_hs, pix_vs}, 0);
    chk(rd_err == 1'b0, "R1", "error flag after reset", 32'(rd_err), 0);
    chk(pix_data == 16'h0, "R1", "pixel after reset", 32'(pix_data), 0);
    chk(m_rready == 1'b1, "R1", "rready", 32'(m_rready), 1);
  endtask

  task automatic t_fill();
    ar_cnt = 0;
    fb_base = 32'h0000_1000;
    pulse_sof();
    idle(60);
    chk(ar_cnt == DEPTH, "R4", "reads with no consumption", 32'(ar_cnt), 32'(DEPTH));
    chk(m_arvalid == 1'b0, "R4", "arvalid with no credit", 32'(m_arvalid), 0);
    check_addrs(32'h0000_1000, DEPTH, "R2");
  endtask

  task automatic t_frame();
    exp_base = 32'h0000_1000;
    pix_idx = 0;
    play_frame();
    chk(pix_idx == H * V, "R6", "pixels shown", 32'(pix_idx), 32'(H * V));
    chk(ar_cnt == WORDS, "R3", "reads per frame", 32'(ar_cnt), 32'(WORDS));
    check_addrs(32'h0000_1000, WORDS, "R2");
    idle(30);
    chk(ar_cnt == WORDS, "R3", "no reads after last word", 32'(ar_cnt), 32'(WORDS));
    chk(m_arvalid == 1'b0, "R3", "arvalid idle after frame", 32'(m_arvalid), 0);
  endtask

  task automatic t_swap();
    ar_cnt = 0;
    fb_base = 32'h0000_2000;
    pulse_sof();
    idle(4);
    fb_base = 32'h0000_8000;
    idle(36);
    exp_base = 32'h0000_2000;
    pix_idx = 0;
    play_frame();
    chk(ar_cnt == WORDS, "R5", "reads in swapped frame", 32'(ar_cnt), 32'(WORDS));
    check_addrs(32'h0000_2000, WORDS, "R5");
  endtask

  task automatic t_error();
    err_addr = 32'h0000_8000 + 32'd20;
    chk(rd_err == 1'b0, "R8", "no error before bad response", 32'(rd_err), 0);
    ar_cnt = 0;
    pulse_sof();
    idle(40);
    exp_base = 32'h0000_8000;
    pix_idx = 0;
    play_frame();
    chk(ar_log[0] == 32'h0000_8000, "R5", "new base on next frame", ar_log[0], 32'h0000_8000);
    check_addrs(32'h0000_8000, WORDS, "R5");
    chk(pix_idx == H * V, "R8", "pixels incl. errored word", 32'(pix_idx), 32'(H * V));
    chk(rd_err == 1'b1, "R8", "error flag set", 32'(rd_err), 1);
    idle(20);
    chk(rd_err == 1'b1, "R8", "error flag sticky", 32'(rd_err), 1);
    err_addr = 32'hFFFF_FFFF;
  endtask

  task automatic t_sync();
    @(negedge clk); vid_hs = 1'b1; vid_vs = 1'b1;
    @(negedge clk); vid_hs = 1'b0; vid_vs = 1'b0;
    chk(pix_hs == 1'b0 && pix_vs == 1'b0, "R7", "sync after 1 cycle", {30'b0, pix_hs, pix_vs}, 0);
    @(negedge clk);
    chk(pix_hs == 1'b1 && pix_vs == 1'b1, "R7", "sync after 2 cycles", {30'b0, pix_hs, pix_vs}, 3);
    @(negedge clk);
    chk(pix_hs == 1'b0 && pix_vs == 1'b0, "R7", "sync after 3 cycles", {30'b0, pix_hs, pix_vs}, 0);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    t_reset();
    t_sync();
    t_fill();
    t_frame();
    t_swap();
    t_error();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule